// File: doc/BRIEF.md
# Dual-Configuration Wrapper Scan Network

This block stitches the scan storage of one clock domain (internal scan chains plus single-bit wrapper boundary cells) onto a set of wrapper scan-in and scan-out pins. It can do this in two ways. The configuration is chosen by a one-bit mode input and held in a configuration register. In the full configuration every element can be both loaded and unloaded. In the split configuration only chains whose flip-flops capture from the same domain stay on paths that end at a scan-out pin. Chains that only capture cross-domain data hang off extra scan-in pins as load-only paths, and their tails are never observed. This shortens the unload path for the phase of test where only same-domain tests remain.

Each element has exactly one two-input source selector in front of it. The selector picks the element's predecessor (a scan-in pin or the tail of another element) according to the active configuration. All routing is given by parameter tables, so the partitioning of chains onto pins happens outside this block. The number of scan-in pins and the number of scan-out pins are independent parameters. Scan-out pins that have no path in the active configuration drive zero. The default table holds a same-domain chain of 10 flops (element 0), two cross-domain chains of 8 and 6 flops (elements 1 and 2), and one output boundary cell (element 3). It uses 3 scan-in pins and 2 scan-out pins.

Top module: `wrap_scan_net`

## Requirements
- R1: While `rst` is high at a rising clock edge, every storage bit clears to 0 and the configuration register returns to full (value 0). From the edge after reset, all scan-out pins read 0.
- R2: Full configuration (`mode_i` = 0): a bit driven on scan-in pin 0 passes through element 0 and then the output cell. It appears on scan-out pin 0 after 11 shifting edges.
- R3: Full configuration: a bit driven on scan-in pin 1 passes through element 1 (8 flops) and then element 2 (6 flops). It appears on scan-out pin 1 after 14 shifting edges.
- R4: Split configuration (`mode_i` = 1): the same-domain chain and the output cell stay on the scan-in 0 to scan-out 0 path, with the same 11-edge latency.
- R5: Split configuration: scan-in pin 1 loads element 1 alone and scan-in pin 2 loads element 2 alone. Neither tail reaches any output, and scan-out pin 1 is held at 0.
- R6: In the full configuration, scan-in pin 2 has no effect on either scan-out pin.
- R7: `mode_i` is taken into the configuration register only on edges where `scan_en` is low. A change of `mode_i` during shifting has no effect until a non-shifting edge.
- R8: On an edge where `scan_en` is low, no storage bit changes.
- R9: Data loaded into the load-only chains in the split configuration is kept across a switch back to full. It is then unloaded on scan-out pin 1, element 2's contents first and then element 1's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock of the domain |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | High: every element shifts one place on this edge |
| mode_i | input | 1 | Requested configuration: 0 full, 1 split |
| si_i | input | NUM_SI | Wrapper scan-in pins, bit n is pin n |
| so_o | output | NUM_SO | Wrapper scan-out pins, bit n is pin n |

## Verification
Each scan-out pin is a direct decode of element tail registers and the configuration register. It therefore reflects a shifting edge in the same cycle. A bit entering a path is due on the pin after exactly the path length in shifting edges: 11 for the same-domain path and 14 for the cross-domain path in full configuration. A mode change is due one non-shifting edge after it is requested. The bench drives all inputs on the falling edge, advances its own per-element model in the same step, and compares both scan-out pins on the following falling edge. Every comparison therefore falls on the cycle after the rising edge that produced it.

// File: rtl/wsn_pkg.sv
package wsn_pkg;

    // Active routing configuration
    typedef enum logic {
        CFG_FULL  = 1'b0,   // every element loaded and unloaded
        CFG_SPLIT = 1'b1    // cross-domain chains load-only
    } cfg_e;

    // Source code meaning "no source": the selector drives zero
    localparam int NO_SRC = -1;

    // Source codes: 0..NUM_SI-1 are scan-in pins, NUM_SI+k is tail of element k
    function automatic bit code_is_pin(int code, int num_si);
        return (code >= 0) && (code < num_si);
    endfunction

    function automatic bit code_is_elem(int code, int num_si);
        return code >= num_si;
    endfunction

endpackage

// File: rtl/wsn_cfg_reg.sv
module wsn_cfg_reg
    import wsn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scan_en,
    input  cfg_e cfg_req,
    output cfg_e cfg_q
);

    // Configuration only moves while nothing is shifting
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_FULL;
        end else if (!scan_en) begin
            cfg_q <= cfg_req;
        end
    end

endmodule

// File: rtl/wsn_src_mux.sv
module wsn_src_mux
    import wsn_pkg::*;
#(
    parameter int NUM_SI     = 3,
    parameter int NUM_ELEM   = 4,
    parameter int CODE_FULL  = 0,
    parameter int CODE_SPLIT = 0
) (
    input  logic [NUM_SI-1:0]   si_i,
    input  logic [NUM_ELEM-1:0] tail_i,
    input  cfg_e                cfg_i,
    output logic                bit_o
);

    logic from_full;
    logic from_split;

    generate
        if (code_is_pin(CODE_FULL, NUM_SI)) begin : g_full_pin
            assign from_full = si_i[CODE_FULL];
        end else if (code_is_elem(CODE_FULL, NUM_SI)) begin : g_full_elem
            assign from_full = tail_i[CODE_FULL-NUM_SI];
        end else begin : g_full_none
            assign from_full = 1'b0;
        end

        if (code_is_pin(CODE_SPLIT, NUM_SI)) begin : g_split_pin
            assign from_split = si_i[CODE_SPLIT];
        end else if (code_is_elem(CODE_SPLIT, NUM_SI)) begin : g_split_elem
            assign from_split = tail_i[CODE_SPLIT-NUM_SI];
        end else begin : g_split_none
            assign from_split = 1'b0;
        end
    endgenerate

    assign bit_o = (cfg_i == CFG_SPLIT) ? from_split : from_full;

endmodule

// File: rtl/wsn_elem.sv
module wsn_elem #(
    parameter int LEN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  logic din,
    output logic head,
    output logic tail
);

    logic [LEN-1:0] bits_q;

    generate
        if (LEN == 1) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst)        bits_q <= '0;
                else if (shift) bits_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)        bits_q <= '0;
                else if (shift) bits_q <= {bits_q[LEN-2:0], din};
            end
        end
    endgenerate

    assign head = bits_q[0];
    assign tail = bits_q[LEN-1];

endmodule

// File: rtl/wrap_scan_net.sv
module wrap_scan_net
    import wsn_pkg::*;
#(
    parameter int NUM_SI   = 3,
    parameter int NUM_SO   = 2,
    parameter int NUM_ELEM = 4,
    parameter int ELEM_LEN   [NUM_ELEM] = '{10, 8, 6, 1},
    parameter int PRED_FULL  [NUM_ELEM] = '{0, 1, 4, 3},
    parameter int PRED_SPLIT [NUM_ELEM] = '{0, 1, 2, 3},
    parameter int OUT_FULL   [NUM_SO]   = '{6, 5},
    parameter int OUT_SPLIT  [NUM_SO]   = '{6, -1}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              mode_i,
    input  logic [NUM_SI-1:0] si_i,
    output logic [NUM_SO-1:0] so_o
);

    cfg_e                cfg_q;
    logic [NUM_ELEM-1:0] elem_din;
    logic [NUM_ELEM-1:0] elem_head;
    logic [NUM_ELEM-1:0] elem_tail;

    wsn_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .cfg_req (cfg_e'(mode_i)),
        .cfg_q   (cfg_q)
    );

    generate
        for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
            wsn_src_mux #(
                .NUM_SI     (NUM_SI),
                .NUM_ELEM   (NUM_ELEM),
                .CODE_FULL  (PRED_FULL[e]),
                .CODE_SPLIT (PRED_SPLIT[e])
            ) u_pred (
                .si_i   (si_i),
                .tail_i (elem_tail),
                .cfg_i  (cfg_q),
                .bit_o  (elem_din[e])
            );

            wsn_elem #(
                .LEN (ELEM_LEN[e])
            ) u_store (
                .clk   (clk),
                .rst   (rst),
                .shift (scan_en),
                .din   (elem_din[e]),
                .head  (elem_head[e]),
                .tail  (elem_tail[e])
            );
        end

        for (genvar o = 0; o < NUM_SO; o++) begin : g_out
            wsn_src_mux #(
                .NUM_SI     (NUM_SI),
                .NUM_ELEM   (NUM_ELEM),
                .CODE_FULL  (OUT_FULL[o]),
                .CODE_SPLIT (OUT_SPLIT[o])
            ) u_obs (
                .si_i   (si_i),
                .tail_i (elem_tail),
                .cfg_i  (cfg_q),
                .bit_o  (so_o[o])
            );
        end
    endgenerate

endmodule

// File: rtl/wsn_checker.sv
module wsn_checker
    import wsn_pkg::*;
#(
    parameter int NUM_SI   = 3,
    parameter int NUM_SO   = 2,
    parameter int NUM_ELEM = 4,
    parameter int PRED_FULL  [NUM_ELEM] = '{0, 1, 4, 3},
    parameter int PRED_SPLIT [NUM_ELEM] = '{0, 1, 2, 3},
    parameter int OUT_SPLIT  [NUM_SO]   = '{6, -1}
) (
    input logic                clk,
    input logic                rst,
    input logic                scan_en,
    input logic [NUM_SI-1:0]   si_i,
    input logic [NUM_SO-1:0]   so_o,
    input cfg_e                cfg_q,
    input logic [NUM_ELEM-1:0] elem_head,
    input logic [NUM_ELEM-1:0] elem_tail
);

    // R1: reset clears every path
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (so_o == '0));

    // R7: configuration frozen across shifting edges
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> $stable(cfg_q));

    // R8: nothing moves without scan enable
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(elem_tail) && $stable(elem_head));

    generate
        for (genvar e = 0; e < NUM_ELEM; e++) begin : g_link
            if (code_is_pin(PRED_FULL[e], NUM_SI)) begin : g_fp
                // R2, R3: full-configuration link from a pin
                a_r2_link_full_pin: assert property (@(posedge clk) disable iff (rst)
                    (scan_en && cfg_q == CFG_FULL) |=> elem_head[e] == $past(si_i[PRED_FULL[e]]));
            end else if (code_is_elem(PRED_FULL[e], NUM_SI)) begin : g_fe
                a_r3_link_full_elem: assert property (@(posedge clk) disable iff (rst)
                    (scan_en && cfg_q == CFG_FULL) |=> elem_head[e] == $past(elem_tail[PRED_FULL[e]-NUM_SI]));
            end
            if (code_is_pin(PRED_SPLIT[e], NUM_SI)) begin : g_sp
                // R4, R5: split-configuration link from a pin
                a_r4_link_split_pin: assert property (@(posedge clk) disable iff (rst)
                    (scan_en && cfg_q == CFG_SPLIT) |=> elem_head[e] == $past(si_i[PRED_SPLIT[e]]));
            end else if (code_is_elem(PRED_SPLIT[e], NUM_SI)) begin : g_se
                a_r4_link_split_elem: assert property (@(posedge clk) disable iff (rst)
                    (scan_en && cfg_q == CFG_SPLIT) |=> elem_head[e] == $past(elem_tail[PRED_SPLIT[e]-NUM_SI]));
            end
        end

        for (genvar o = 0; o < NUM_SO; o++) begin : g_idle
            if (OUT_SPLIT[o] < 0) begin : g_zero
                // R5: unmapped scan-out held at zero in split configuration
                a_r5_idle_out_zero: assert property (@(posedge clk) disable iff (rst)
                    (cfg_q == CFG_SPLIT) |-> (so_o[o] == 1'b0));
            end
        end
    endgenerate

endmodule

bind wrap_scan_net wsn_checker #(
    .NUM_SI     (NUM_SI),
    .NUM_SO     (NUM_SO),
    .NUM_ELEM   (NUM_ELEM),
    .PRED_FULL  (PRED_FULL),
    .PRED_SPLIT (PRED_SPLIT),
    .OUT_SPLIT  (OUT_SPLIT)
) u_wsn_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .si_i      (si_i),
    .so_o      (so_o),
    .cfg_q     (cfg_q),
    .elem_head (elem_head),
    .elem_tail (elem_tail)
);

// File: tb/wrap_scan_net_test.sv
module wrap_scan_net_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       scan_en;
    logic       mode_i;
    logic [2:0] si_i;
    logic [1:0] so_o;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the default element set
    logic [9:0] m_e0;
    logic [7:0] m_e1;
    logic [5:0] m_e2;
    logic       m_e3;
    logic       m_split;

    always #10 clk = ~clk;

    wrap_scan_net uut (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .mode_i  (mode_i),
        .si_i    (si_i),
        .so_o    (so_o)
    );

    function automatic int test_cycles(int s_in, int s_out, int pats);
        int hi = (s_in > s_out) ? s_in : s_out;
        int lo = (s_in > s_out) ? s_out : s_in;
        return (hi + 1) * pats + lo;
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: so_o actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] expect_out();
        return {m_split ? 1'b0 : m_e2[5], m_e3};
    endfunction

    // Drive one cycle on the falling edge, advance model, compare after the rising edge
    task automatic step(logic se, logic md, logic [2:0] sin, string tag);
        scan_en = se;
        mode_i  = md;
        si_i    = sin;
        if (se) begin
            m_e3 = m_e0[9];
            m_e0 = {m_e0[8:0], sin[0]};
            if (m_split) begin
                m_e2 = {m_e2[4:0], sin[2]};
                m_e1 = {m_e1[6:0], sin[1]};
            end else begin
                m_e2 = {m_e2[4:0], m_e1[7]};
                m_e1 = {m_e1[6:0], sin[1]};
            end
        end else begin
            m_split = md;
        end
        @(negedge clk);
        check(tag, so_o, expect_out());
    endtask

    task automatic do_reset();
        rst = 1'b1;
        scan_en = 1'b0;
        mode_i = 1'b0;
        si_i = '0;
        m_e0 = '0; m_e1 = '0; m_e2 = '0; m_e3 = 1'b0; m_split = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", so_o, 2'b00);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        process::self().srandom(32'h5CA1);
        @(negedge clk);
        do_reset();

        // R2, R3, R6: full configuration with random data on all pins (pin 2 must not matter)
        for (int i = 0; i < 80; i++) step(1'b1, 1'b0, 3'($urandom), "R2 R3 R6 full shift");
        // directed: single one through the 11-long path and the 14-long path
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, (i == 0) ? 3'b011 : 3'b100, "R2 R3 marker");

        // R8: hold with scan_en low, then request split
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 3'($urandom), "R8 hold");
        step(1'b0, 1'b1, 3'($urandom), "R7 enter split");

        // R4, R5: split configuration
        for (int i = 0; i < 80; i++) step(1'b1, 1'b1, 3'($urandom), "R4 R5 split shift");
        // directed: all-ones on load-only pins, so pin 1 must stay zero
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 3'b110, "R5 load-only ones");

        // R7: request full during shifting, must stay split
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 3'($urandom), "R7 mode change mid-shift");
        // load a known pattern into the load-only chains
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, {1'(i & 1), 1'(i >> 1), 1'b0}, "R5 known load");
        step(1'b0, 1'b0, 3'b000, "R7 leave split");

        // R9: unload the load-only contents in full configuration
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 3'b000, "R9 unload kept data");

        // R8 in split with mode requests toggling while idle
        for (int i = 0; i < 6; i++) step(1'b0, 1'(i & 1), 3'($urandom), "R8 idle toggle");

        // R1: reset in the middle of activity
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 3'b111, "R4 fill");
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 3'b000, "R1 after reset");

        $display("Test time full cfg, 100 patterns: %0d cycles", test_cycles(14, 14, 100));
        $display("Test time split cfg, 100 patterns: %0d cycles", test_cycles(11, 11, 100));
        $display("Test time 100/101 split example, 100 patterns: %0d cycles", test_cycles(100, 101, 100));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule